// File: doc/BRIEF.md
# Serial Shift Register with Parallel Holding Stage and Reload Path

The block is a serial-to-parallel converter built from two registers of equal width. A shift register takes one bit per shift strobe from a serial input into its lowest bit and moves the contents toward its highest bit. The highest bit is always visible on a serial output, so the serial input of a further unit can be fed from it to build longer words. A separate store strobe copies the shift register into a holding register, whose bits drive the parallel output. The holding register can also be copied back into the shift register, which lets a stored word be sent out serially again.

Both strobes are ordinary data inputs inside one system-clock domain. Each strobe passes through a synchronizer chain and then an edge detector. The shift register acts only on a falling strobe edge, and the holding register acts only on a rising strobe edge. An active-low select freezes both registers. A direction input picks whether a store is allowed, or whether a shift edge with the store strobe held high reloads the shift register.

Top module: `shift_store_reg`

## Requirements
- R1: The shift register changes only when a falling edge of the shift strobe is detected. Holding the strobe high, holding it low, or toggling the serial input alone leaves it unchanged.
- R2: While `sel_n` is 1, neither a shift-strobe edge nor a store-strobe edge changes either register.
- R3: With `sel_n`=0 and `rw`=0, each shift edge moves bit i to bit i+1 and loads `ser_in` into bit 0.
- R4: With `sel_n`=0 and `rw`=1, a shift edge shifts as in R3 when the synchronized store strobe is low. When that strobe is high, the same edge copies the holding register into the shift register and no shift takes place.
- R5: The holding register loads the shift register on a rising store-strobe edge only when `sel_n`=0 and `rw`=0. Otherwise it keeps its value.
- R6: `par_out[i]` is bit i of the holding register. `ser_out` is always the top bit of the shift register, so two chained units act as one register of twice the width.
- R7: A change on `sel_n` or `rw` never acts as a strobe edge. In particular, neither of these causes a store or a shift: `sel_n` falling while the store strobe is high, `rw` falling while the store strobe is high, or `sel_n` rising while the shift strobe is high.
- R8: When a shift edge and a store edge are detected in the same cycle, the holding register captures the shift register value from before that shift.
- R9: A synchronous active-high `rst` clears both registers to zero.
- R10: A strobe transition presented between clock edges takes effect at the SYNC_STAGES+1-th rising clock edge after it, and not at any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Unit select, active low; high freezes both registers |
| rw | input | 1 | 0: stores allowed; 1: stores blocked and reload enabled |
| shift_stb | input | 1 | Shift strobe, acts on its falling edge |
| store_stb | input | 1 | Store strobe, acts on its rising edge |
| ser_in | input | 1 | Serial data into bit 0 |
| ser_out | output | 1 | Top bit of the shift register |
| par_out | output | WIDTH | Holding register contents |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=2. At that width every one of the 256 possible words can be shifted in, stored and read back on the parallel output. A second unit fed from the first unit's serial output is checked in the same sweep. The reduced width also keeps each directed control-ordering case short: reload, the blocked store, the false-edge sequences on the select and direction lines, and coincident edges. This makes cycle-exact latency checks cheap.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_SHIFT  = 2'd1,
      OP_RELOAD = 2'd2
   } sh_op_e;

   // Action of the shift register for one system-clock cycle.
   function automatic sh_op_e shift_op(input logic sel_n,
                                       input logic rw,
                                       input logic store_hi,
                                       input logic fall_evt);
      if (!fall_evt || sel_n) return OP_HOLD;
      if (rw && store_hi)     return OP_RELOAD;
      return OP_SHIFT;
   endfunction

endpackage

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
   parameter int STAGES      = 2,
   parameter bit ACTIVE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_i,
   output logic lvl_o,
   output logic evt_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ssr_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o = chain_q[STAGES-1];

   if (ACTIVE_RISE) begin : g_rise
      assign evt_o = lvl_o & ~last_q;
   end else begin : g_fall
      assign evt_o = ~lvl_o & last_q;
   end

   AST_ONE_EVENT_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
      evt_o |=> !evt_o);   // R10

endmodule

// File: rtl/ssr_shift_core.sv
module ssr_shift_core
   import ssr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_n,
   input  logic             rw,
   input  logic             store_hi,
   input  logic             fall_evt,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] reload_i,
   output logic [WIDTH-1:0] bits_q
);

   sh_op_e           op;
   logic [WIDTH-1:0] nxt;

   assign op = shift_op(sel_n, rw, store_hi, fall_evt);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_low;
      if (i == 0) begin : g_head
         assign from_low = ser_in;
      end else begin : g_body
         assign from_low = bits_q[i-1];
      end
      assign nxt[i] = (op == OP_SHIFT)  ? from_low    :
                      (op == OP_RELOAD) ? reload_i[i] : bits_q[i];
   end

   always_ff @(posedge clk) begin
      if (rst) bits_q <= '0;
      else     bits_q <= nxt;
   end

   AST_SHIFT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
      !fall_evt |=> $stable(bits_q));   // R1
   AST_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (rst)
      sel_n |=> $stable(bits_q));   // R2
   AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
      (fall_evt && !sel_n && !(rw && store_hi)) |=>
         bits_q == {$past(bits_q[WIDTH-2:0]), $past(ser_in)});   // R3
   AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (fall_evt && !sel_n && rw && store_hi) |=> bits_q == $past(reload_i));   // R4

endmodule

// File: rtl/ssr_store_reg.sv
module ssr_store_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_n,
   input  logic             rw,
   input  logic             rise_evt,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic take;
   assign take = rise_evt & ~sel_n & ~rw;

   always_ff @(posedge clk) begin
      if (rst)       q_o <= '0;
      else if (take) q_o <= d_i;
   end

   AST_STORE_GATED: assert property (@(posedge clk) disable iff (rst)
      !(rise_evt && !sel_n && !rw) |=> $stable(q_o));   // R5
   AST_STORE_PRE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (rise_evt && !sel_n && !rw) |=> q_o == $past(d_i));   // R8

endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_n,
   input  logic             rw,
   input  logic             shift_stb,
   input  logic             store_stb,
   input  logic             ser_in,
   output logic             ser_out,
   output logic [WIDTH-1:0] par_out
);

   if (WIDTH < 2) begin : g_bad_width
      $error("shift_store_reg: WIDTH must be at least 2");
   end

   logic             shift_lvl, shift_fall;
   logic             store_lvl, store_rise;
   logic [WIDTH-1:0] sh_bits;
   logic [WIDTH-1:0] hold_bits;

   ssr_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_RISE(1'b0)) u_shift_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_i (shift_stb),
      .lvl_o (shift_lvl),
      .evt_o (shift_fall)
   );

   ssr_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_RISE(1'b1)) u_store_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_i (store_stb),
      .lvl_o (store_lvl),
      .evt_o (store_rise)
   );

   ssr_shift_core #(.WIDTH(WIDTH)) u_core (
      .clk      (clk),
      .rst      (rst),
      .sel_n    (sel_n),
      .rw       (rw),
      .store_hi (store_lvl),
      .fall_evt (shift_fall),
      .ser_in   (ser_in),
      .reload_i (hold_bits),
      .bits_q   (sh_bits)
   );

   ssr_store_reg #(.WIDTH(WIDTH)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .sel_n    (sel_n),
      .rw       (rw),
      .rise_evt (store_rise),
      .d_i      (sh_bits),
      .q_o      (hold_bits)
   );

   assign ser_out = sh_bits[WIDTH-1];
   assign par_out = hold_bits;

   AST_FALL_AT_LOW_LEVEL: assert property (@(posedge clk) disable iff (rst)
      shift_fall |-> !shift_lvl);   // R1
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (par_out == '0 && ser_out == 1'b0));   // R9

endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sel_n = 1'b0, rw = 1'b0, shift_stb = 1'b0, store_stb = 1'b0, ser_in = 1'b0;
   logic         ser_out, ser_out_b;
   logic [W-1:0] par_out, par_out_b;

   logic [W-1:0] m_sh, m_st, m_sh_b, m_st_b;
   int           checks = 0, errors = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   shift_store_reg #(.WIDTH(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .sel_n(sel_n), .rw(rw), .shift_stb(shift_stb),
      .store_stb(store_stb), .ser_in(ser_in), .ser_out(ser_out), .par_out(par_out));

   shift_store_reg #(.WIDTH(W), .SYNC_STAGES(2)) uut_b (
      .clk(clk), .rst(rst), .sel_n(sel_n), .rw(rw), .shift_stb(shift_stb),
      .store_stb(store_stb), .ser_in(ser_out), .ser_out(ser_out_b), .par_out(par_out_b));

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic shift_pulse(input logic b);
      logic [W-1:0] old_sh;
      ser_in = b;
      shift_stb = 1'b1;
      idle(4);
      shift_stb = 1'b0;
      idle(4);
      old_sh = m_sh;
      if (!sel_n) begin
         if (rw && store_stb) begin
            m_sh   = m_st;
            m_sh_b = m_st_b;
         end else begin
            m_sh   = {m_sh[W-2:0], b};
            m_sh_b = {m_sh_b[W-2:0], old_sh[W-1]};
         end
      end
   endtask

   task automatic store_pulse();
      store_stb = 1'b1;
      idle(4);
      if (!sel_n && !rw) begin
         m_st   = m_sh;
         m_st_b = m_sh_b;
      end
      store_stb = 1'b0;
      idle(4);
   endtask

   task automatic load_word(input logic [W-1:0] v);
      for (int k = W - 1; k >= 0; k--) shift_pulse(v[k]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      m_sh = '0; m_st = '0; m_sh_b = '0; m_st_b = '0;
      idle(3);
      rst = 1'b0;
      idle(1);
      chk("R9 reset par_out", par_out, 0);
      chk("R9 reset ser_out", ser_out, 0);

      // R10: a store edge acts on the third rising clock edge after it
      shift_pulse(1'b1);
      store_stb = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R10 no store before sync latency", par_out, 0);
      @(negedge clk);
      chk("R10 store at latency", par_out, 1);
      m_st = m_sh; m_st_b = m_sh_b;
      store_stb = 1'b0;
      idle(4);

      // R3 / R6: every word shifted in, stored and read back; chained unit too
      for (int v = 0; v < (1 << W); v++) begin
         load_word(v[W-1:0]);
         chk("R6 ser_out is top bit", ser_out, v[W-1]);
         store_pulse();
         chk("R3 word stored", par_out, v[W-1:0]);
         chk("R6 chained unit", par_out_b, m_st_b);
      end

      // R2: deselected unit ignores both strobes
      load_word(8'h96);
      store_pulse();
      sel_n = 1'b1;
      shift_pulse(1'b0); shift_pulse(1'b1); shift_pulse(1'b1);
      store_pulse();
      chk("R2 holding frozen", par_out, 8'h96);
      sel_n = 1'b0;
      store_pulse();
      chk("R2 shift frozen", par_out, 8'h96);

      // R4: shift with store strobe low, reload with it high
      load_word(8'hA5);
      store_pulse();
      load_word(8'h3C);
      rw = 1'b1;
      shift_pulse(1'b1);
      chk("R4 shift with rw high", ser_out, 0);
      store_stb = 1'b1;
      idle(4);
      chk("R5 no store with rw high", par_out, 8'hA5);
      shift_pulse(1'b0);
      chk("R4 reload top bit", ser_out, 1);
      store_stb = 1'b0;
      idle(4);
      for (int k = W - 1; k >= 0; k--) begin
         chk("R4 reloaded word shifts out", ser_out, m_sh[W-1]);
         shift_pulse(1'b0);
      end
      rw = 1'b0;

      // R7: control transitions are not strobe edges
      load_word(8'h5A);
      store_pulse();
      shift_pulse(1'b1);
      sel_n = 1'b1;
      store_stb = 1'b1;
      idle(4);
      sel_n = 1'b0;
      idle(4);
      chk("R7 select fall with store high", par_out, 8'h5A);
      store_stb = 1'b0;
      idle(4);
      rw = 1'b1;
      store_stb = 1'b1;
      idle(4);
      rw = 1'b0;
      idle(4);
      chk("R7 rw fall with store high", par_out, 8'h5A);
      store_stb = 1'b0;
      idle(4);
      shift_stb = 1'b1;
      idle(4);
      sel_n = 1'b1;
      idle(4);
      shift_stb = 1'b0;
      idle(4);
      sel_n = 1'b0;
      idle(4);
      store_pulse();
      chk("R7 select rise with shift high", par_out, m_sh);

      // R8: coincident edges store the pre-shift value
      load_word(8'hC3);
      shift_stb = 1'b1;
      ser_in = 1'b1;
      idle(4);
      shift_stb = 1'b0;
      store_stb = 1'b1;
      idle(4);
      chk("R8 pre-shift value stored", par_out, 8'hC3);
      m_st = 8'hC3;
      m_sh = {m_sh[W-2:0], 1'b1};
      store_stb = 1'b0;
      idle(4);
      store_pulse();
      chk("R8 shift also happened", par_out, 8'h87);

      // R1: no falling shift edge, no change
      ser_in = 1'b1;
      idle(6);
      ser_in = 1'b0;
      shift_stb = 1'b1;
      idle(6);
      store_pulse();
      chk("R1 shift register unchanged", par_out, 8'h87);
      shift_stb = 1'b0;
      idle(4);
      m_sh = {m_sh[W-2:0], 1'b0};

      // R9: reset clears both registers
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      m_sh = '0; m_st = '0; m_sh_b = '0; m_st_b = '0;
      idle(1);
      chk("R9 reset clears holding", par_out, 0);
      store_pulse();
      chk("R9 reset clears shift", par_out, 0);

      finish_run();
   end

endmodule